// File: doc/BRIEF.md
# Two-Level Nested Interrupt Controller

This block arbitrates among six interrupt sources on behalf of a small 8-bit CPU core. Each source is gated by its own enable bit and by a master enable, and a priority register puts each source on either the high or the low level. The controller picks one winner, presents its 16-bit vector address on a registered request strobe, and tracks which levels are currently being serviced. A low-level routine can be preempted only by a high-level request. A high-level routine cannot be preempted at all.

Two external pins are active low. For each pin a type bit selects one of two behaviours. In level mode the request follows the pin. In edge mode a falling edge sets a latched flag. The controller also holds the overflow flags of the two basic timers, which are set by one-cycle overflow pulses. When the CPU acknowledges a vector, the controller clears the edge flags and timer flags that it owns. The serial and timer-2 requests are plain inputs, and their owners keep them set until software clears them. A return-from-interrupt pulse closes the innermost open level.

Top module: `irq_nest_ctrl`

## Requirements
- R1: After reset, `irq_req` is 0, `in_svc` is 00, `ext_flag` is 00 and `tmr_flag` is 00.
- R2: Source index i (0 ext pin 0, 1 timer 0, 2 ext pin 1, 3 timer 1, 4 serial, 5 timer 2) vectors to 0x0003 + 8*i, giving 0003, 000B, 0013, 001B, 0023, 002B.
- R3: When `en_reg[7]` is 0, no request is raised. When it is 1, source i can raise a request only while `en_reg[i]` is 1.
- R4: Among pending requests on the same level, the lowest source index wins.
- R5: When `pri_reg[i]` is 1, source i is on the high level. A pending high-level request beats any low-level request, whatever their indices. `irq_lvl` gives the level of the presented vector (1 means high).
- R6: While a low-level routine is open, only high-level requests are presented. While a high-level routine is open, no request is presented.
- R7: A `reti` pulse clears `in_svc[1]` if it is set, and otherwise clears `in_svc[0]`.
- R8: With `ext_type[k]`=0, pin k requests while `ext_pin_n[k]` is low. The request is not latched, and `ext_flag[k]` stays 0.
- R9: With `ext_type[k]`=1, a falling edge on `ext_pin_n[k]` sets `ext_flag[k]`. The flag holds after the pin returns high and clears when its vector is acknowledged.
- R10: A one-cycle pulse on `tmr_ovf[k]` sets `tmr_flag[k]`, which clears when its vector is acknowledged.
- R11: Acknowledging a serial or timer-2 vector leaves the source untouched, so once no routine blocks it the request appears again while the input stays high.
- R12: `irq_req` rises one cycle after a level source becomes pending. An `ack` while `irq_req` is 1 drops `irq_req` in the next cycle and sets `in_svc[irq_lvl]`. An `ack` while `irq_req` is 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_reg | input | 8 | Bit 7 master enable, bits 5..0 per-source enables |
| pri_reg | input | 6 | Per-source level, 1 = high |
| ext_type | input | 2 | Per-pin trigger type, 1 = falling edge, 0 = low level |
| ext_pin_n | input | 2 | External active-low request pins |
| tmr_ovf | input | 2 | Overflow pulses of timer 0 (bit 0) and timer 1 (bit 1) |
| ser_req | input | 1 | Serial receive/transmit request level |
| t2_req | input | 1 | Timer 2 overflow/external request level |
| ack | input | 1 | CPU accepts the presented vector |
| reti | input | 1 | CPU returns from the innermost routine |
| irq_req | output | 1 | Request strobe to the CPU |
| irq_vec | output | 16 | Vector address of the presented request |
| irq_lvl | output | 1 | Level of the presented request |
| in_svc | output | 2 | In-service bits, [1] high level, [0] low level |
| ext_flag | output | 2 | Latched edge flags of the external pins |
| tmr_flag | output | 2 | Timer 0/1 overflow flags |

## Verification
Each source reaches the request strobe after a fixed number of cycles. A level source (a pin in level mode, serial, timer 2) shows on `irq_req` one edge after it is driven. An edge-mode pin or a timer pulse first sets its flag at the next edge, and the request appears one edge after that. An acknowledge clears `irq_req`, the owned flag and sets `in_svc` at the next edge. Because the request is registered from the state before that edge, a newly eligible request appears one edge later still. The bench drives inputs one time unit after a rising edge. It advances a counted number of edges for each case and samples only after that count has elapsed, so each check falls in the cycle where the result is due.

// File: rtl/irq_nest_pkg.sv
package irq_nest_pkg;

    localparam int NSRC  = 6;
    localparam int SRC_W = $clog2(NSRC);
    localparam int NEXT  = 2;
    localparam int NTMR  = 2;

    // source indices; their order is the fixed in-level ranking
    localparam logic [SRC_W-1:0] SRC_EXT0 = SRC_W'(0);
    localparam logic [SRC_W-1:0] SRC_TMR0 = SRC_W'(1);
    localparam logic [SRC_W-1:0] SRC_EXT1 = SRC_W'(2);
    localparam logic [SRC_W-1:0] SRC_TMR1 = SRC_W'(3);
    localparam logic [SRC_W-1:0] SRC_SER  = SRC_W'(4);
    localparam logic [SRC_W-1:0] SRC_TMR2 = SRC_W'(5);

    localparam logic [15:0] VEC_BASE   = 16'h0003;
    localparam int          VEC_STRIDE = 3;  // log2 of byte spacing

    function automatic logic [15:0] vec_of(input logic [SRC_W-1:0] idx);
        return VEC_BASE + (16'(idx) << VEC_STRIDE);
    endfunction

    typedef struct packed {
        logic             req;
        logic [SRC_W-1:0] idx;
        logic             lvl;
        logic [NTMR-1:0]  tflag;
    } ctrl_st_t;

    typedef struct packed {
        logic pin;
        logic flag;
    } pin_st_t;

endpackage

// File: rtl/irq_edge_unit.sv
module irq_edge_unit
    import irq_nest_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_n,
    input  logic edge_mode,
    input  logic clr,
    output logic req,
    output logic flag
);
    pin_st_t st_d, st_q;
    logic    fall;

    always_comb begin
        st_d     = st_q;
        fall     = st_q.pin & ~pin_n;
        st_d.pin = pin_n;
        if (!edge_mode)
            st_d.flag = 1'b0;
        else if (fall)
            st_d.flag = 1'b1;
        else if (clr)
            st_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pin  <= 1'b1;
            st_q.flag <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign req  = edge_mode ? st_q.flag : ~pin_n;
    assign flag = st_q.flag;

endmodule

// File: rtl/irq_pick.sv
module irq_pick
    import irq_nest_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic [N-1:0]     pend,
    input  logic [N-1:0]     pri,
    input  logic [1:0]       in_svc,
    output logic             valid,
    output logic [SRC_W-1:0] idx,
    output logic             lvl
);
    logic [N-1:0]     hi_c, lo_c;
    logic             hi_v, lo_v;
    logic [SRC_W-1:0] hi_i, lo_i;
    logic             allow_hi, allow_lo;

    assign hi_c     = pend & pri;
    assign lo_c     = pend & ~pri;
    assign allow_hi = ~in_svc[1];
    assign allow_lo = ~in_svc[1] & ~in_svc[0];

    // scan downward so the lowest set index is the last one kept
    always_comb begin
        hi_v = 1'b0;
        hi_i = '0;
        lo_v = 1'b0;
        lo_i = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hi_c[i]) begin
                hi_v = 1'b1;
                hi_i = SRC_W'(i);
            end
            if (lo_c[i]) begin
                lo_v = 1'b1;
                lo_i = SRC_W'(i);
            end
        end
    end

    always_comb begin
        valid = 1'b0;
        idx   = '0;
        lvl   = 1'b0;
        if (allow_hi && hi_v) begin
            valid = 1'b1;
            idx   = hi_i;
            lvl   = 1'b1;
        end else if (allow_lo && lo_v) begin
            valid = 1'b1;
            idx   = lo_i;
        end
    end

endmodule

// File: rtl/irq_nest_track.sv
module irq_nest_track (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take,
    input  logic       take_lvl,
    input  logic       reti,
    output logic [1:0] in_svc
);
    logic [1:0] svc_d, svc_q;

    always_comb begin
        svc_d = svc_q;
        if (reti) begin
            if (svc_q[1])
                svc_d[1] = 1'b0;
            else
                svc_d[0] = 1'b0;
        end
        if (take)
            svc_d[take_lvl] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            svc_q <= 2'b00;
        else
            svc_q <= svc_d;
    end

    assign in_svc = svc_q;

endmodule

// File: rtl/irq_nest_ctrl.sv
module irq_nest_ctrl
    import irq_nest_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  en_reg,
    input  logic [5:0]  pri_reg,
    input  logic [1:0]  ext_type,
    input  logic [1:0]  ext_pin_n,
    input  logic [1:0]  tmr_ovf,
    input  logic        ser_req,
    input  logic        t2_req,
    input  logic        ack,
    input  logic        reti,
    output logic        irq_req,
    output logic [15:0] irq_vec,
    output logic        irq_lvl,
    output logic [1:0]  in_svc,
    output logic [1:0]  ext_flag,
    output logic [1:0]  tmr_flag
);
    localparam logic [SRC_W-1:0] EXT_IDX [NEXT] = '{SRC_EXT0, SRC_EXT1};
    localparam logic [SRC_W-1:0] TMR_IDX [NTMR] = '{SRC_TMR0, SRC_TMR1};

    ctrl_st_t         st_d, st_q;
    logic [NEXT-1:0]  ext_req, ext_clr;
    logic [NTMR-1:0]  tmr_clr;
    logic [NSRC-1:0]  raw, pend;
    logic             take;
    logic             pk_valid, pk_lvl;
    logic [SRC_W-1:0] pk_idx;

    assign take = ack & st_q.req;

    for (genvar k = 0; k < NEXT; k++) begin : g_ext
        assign ext_clr[k] = take && (st_q.idx == EXT_IDX[k]);
        irq_edge_unit u_pin (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_n     (ext_pin_n[k]),
            .edge_mode (ext_type[k]),
            .clr       (ext_clr[k]),
            .req       (ext_req[k]),
            .flag      (ext_flag[k])
        );
    end

    for (genvar k = 0; k < NTMR; k++) begin : g_tmr
        assign tmr_clr[k] = take && (st_q.idx == TMR_IDX[k]);
    end

    always_comb begin
        raw           = '0;
        raw[SRC_EXT0] = ext_req[0];
        raw[SRC_TMR0] = st_q.tflag[0];
        raw[SRC_EXT1] = ext_req[1];
        raw[SRC_TMR1] = st_q.tflag[1];
        raw[SRC_SER]  = ser_req;
        raw[SRC_TMR2] = t2_req;
        pend          = raw & en_reg[NSRC-1:0] & {NSRC{en_reg[7]}};
    end

    irq_pick #(.N(NSRC)) u_pick (
        .pend   (pend),
        .pri    (pri_reg),
        .in_svc (in_svc),
        .valid  (pk_valid),
        .idx    (pk_idx),
        .lvl    (pk_lvl)
    );

    irq_nest_track u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (take),
        .take_lvl (st_q.lvl),
        .reti     (reti),
        .in_svc   (in_svc)
    );

    always_comb begin
        st_d     = st_q;
        st_d.req = pk_valid & ~take;
        st_d.idx = pk_idx;
        st_d.lvl = pk_lvl;
        for (int k = 0; k < NTMR; k++) begin
            if (tmr_ovf[k])
                st_d.tflag[k] = 1'b1;
            else if (tmr_clr[k])
                st_d.tflag[k] = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign irq_req  = st_q.req;
    assign irq_vec  = vec_of(st_q.idx);
    assign irq_lvl  = st_q.lvl;
    assign tmr_flag = st_q.tflag;

endmodule

// File: rtl/irq_nest_chk.sv
module irq_nest_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  en_reg,
    input logic [1:0]  tmr_ovf,
    input logic        ack,
    input logic        reti,
    input logic        irq_req,
    input logic [15:0] irq_vec,
    input logic        irq_lvl,
    input logic [1:0]  in_svc,
    input logic [1:0]  tmr_flag
);
    a_r6_high_blocks_all: assert property (@(posedge clk) disable iff (!rst_n)
        in_svc[1] |-> !irq_req);

    a_r6_low_only_high: assert property (@(posedge clk) disable iff (!rst_n)
        (in_svc[0] && irq_req) |-> irq_lvl);

    a_r12_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack) |=> !irq_req);

    a_r12_ack_marks_high: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack && irq_lvl) |=> in_svc[1]);

    a_r12_ack_marks_low: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && ack && !irq_lvl) |=> in_svc[0]);

    a_r7_reti_inner: assert property (@(posedge clk) disable iff (!rst_n)
        (reti && !ack && in_svc == 2'b11) |=> in_svc == 2'b01);

    a_r2_vec_shape: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (irq_vec[2:0] == 3'b011 && irq_vec[15:6] == 10'd0));

    a_r3_master_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_reg[7] |=> !irq_req);

    a_r10_tmr0_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_flag[0]) |-> $past(tmr_ovf[0]));

    a_r10_tmr1_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tmr_flag[1]) |-> $past(tmr_ovf[1]));

endmodule

bind irq_nest_ctrl irq_nest_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_reg   (en_reg),
    .tmr_ovf  (tmr_ovf),
    .ack      (ack),
    .reti     (reti),
    .irq_req  (irq_req),
    .irq_vec  (irq_vec),
    .irq_lvl  (irq_lvl),
    .in_svc   (in_svc),
    .tmr_flag (tmr_flag)
);

// File: tb/irq_nest_ctrl_test.sv
module irq_nest_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  en_reg = 8'hBF;
    logic [5:0]  pri_reg = 6'h00;
    logic [1:0]  ext_type = 2'b00;
    logic [1:0]  ext_pin_n = 2'b11;
    logic [1:0]  tmr_ovf = 2'b00;
    logic        ser_req = 1'b0;
    logic        t2_req = 1'b0;
    logic        ack = 1'b0;
    logic        reti = 1'b0;
    logic        irq_req;
    logic [15:0] irq_vec;
    logic        irq_lvl;
    logic [1:0]  in_svc;
    logic [1:0]  ext_flag;
    logic [1:0]  tmr_flag;

    int n_chk = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    irq_nest_ctrl uut (
        .clk(clk), .rst_n(rst_n), .en_reg(en_reg), .pri_reg(pri_reg),
        .ext_type(ext_type), .ext_pin_n(ext_pin_n), .tmr_ovf(tmr_ovf),
        .ser_req(ser_req), .t2_req(t2_req), .ack(ack), .reti(reti),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_lvl(irq_lvl),
        .in_svc(in_svc), .ext_flag(ext_flag), .tmr_flag(tmr_flag)
    );

    task automatic tick(input int n = 1);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_ack();
        ack = 1'b1; tick(); ack = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1; tick(); reti = 1'b0;
    endtask

    // drive source i; every kind shows its request within two edges
    task automatic raise(input int i, input logic on);
        case (i)
            0: ext_pin_n[0] = ~on;
            1: if (on) begin tmr_ovf[0] = 1'b1; tick(); tmr_ovf[0] = 1'b0; end
            2: ext_pin_n[1] = ~on;
            3: if (on) begin tmr_ovf[1] = 1'b1; tick(); tmr_ovf[1] = 1'b0; end
            4: ser_req = on;
            default: t2_req = on;
        endcase
    endtask

    task automatic t_reset();
        chk("R1 req", irq_req, 0);
        chk("R1 in_svc", in_svc, 0);
        chk("R1 ext_flag", ext_flag, 0);
        chk("R1 tmr_flag", tmr_flag, 0);
    endtask

    task automatic t_vectors();
        for (int i = 0; i < 6; i++) begin
            raise(i, 1'b1);
            tick(2);
            chk("R2 req", irq_req, 1);
            chk("R2 vec", irq_vec, 32'h0003 + 8 * i);
            do_ack();
            chk("R12 ack drops req", irq_req, 0);
            chk("R12 ack sets low in_svc", in_svc, 2'b01);
            if (i == 1 || i == 3) chk("R10 tmr flag cleared by ack", tmr_flag, 0);
            raise(i, 1'b0);
            do_reti();
            chk("R7 reti closes low", in_svc, 0);
            tick(2);
        end
    endtask

    task automatic t_enable();
        en_reg = 8'h3F; ser_req = 1'b1; tick(2);
        chk("R3 master off", irq_req, 0);
        en_reg = 8'h80 | 8'h2F; tick(2);
        chk("R3 source bit off", irq_req, 0);
        en_reg = 8'hBF; tick();
        chk("R3 enabled req", irq_req, 1);
        chk("R3 enabled vec", irq_vec, 32'h0023);
        ser_req = 1'b0; tick();
        chk("R3 source gone", irq_req, 0);
    endtask

    task automatic t_order();
        ext_pin_n[1] = 1'b0; ser_req = 1'b1; t2_req = 1'b1; tick();
        chk("R4 lowest index wins", irq_vec, 32'h0013);
        chk("R12 one-cycle latency", irq_req, 1);
        do_ack();
        ext_pin_n[1] = 1'b1; tick();
        chk("R6 low blocks low", irq_req, 0);
        do_reti(); tick();
        chk("R4 next in order req", irq_req, 1);
        chk("R4 next in order vec", irq_vec, 32'h0023);
        ser_req = 1'b0; t2_req = 1'b0; tick(2);
    endtask

    task automatic t_prio_nest();
        pri_reg = 6'b100000;
        ext_pin_n[0] = 1'b0; ser_req = 1'b1; t2_req = 1'b1; tick();
        chk("R5 high beats low vec", irq_vec, 32'h002B);
        chk("R5 level out", irq_lvl, 1);
        ext_pin_n[0] = 1'b1; t2_req = 1'b0; tick();
        chk("R5 low presented", irq_vec, 32'h0023);
        do_ack();
        chk("R12 low in service", in_svc, 2'b01);
        t2_req = 1'b1; ext_pin_n[0] = 1'b0; tick();
        chk("R6 high preempts low", irq_req, 1);
        chk("R6 preempt vec", irq_vec, 32'h002B);
        do_ack();
        chk("R6 both in service", in_svc, 2'b11);
        t2_req = 1'b0; tick();
        chk("R6 high blocks all", irq_req, 0);
        do_reti();
        chk("R7 reti closes high first", in_svc, 2'b01);
        tick();
        chk("R6 low still blocks low", irq_req, 0);
        do_reti();
        chk("R7 reti closes low", in_svc, 2'b00);
        tick();
        chk("R4 pending low resumes", irq_vec, 32'h0003);
        ext_pin_n[0] = 1'b1; ser_req = 1'b0; pri_reg = 6'h00; tick(2);
    endtask

    task automatic t_edge();
        ext_type[0] = 1'b1; tick();
        ext_pin_n[0] = 1'b0; tick();
        chk("R9 flag set on fall", ext_flag, 2'b01);
        chk("R9 req not yet", irq_req, 0);
        ext_pin_n[0] = 1'b1; tick();
        chk("R9 req from flag", irq_req, 1);
        tick();
        chk("R9 flag holds after pin high", ext_flag, 2'b01);
        do_ack();
        chk("R9 flag cleared on ack", ext_flag, 2'b00);
        do_reti(); tick(2);
        chk("R9 no retrigger", irq_req, 0);
        ext_type[0] = 1'b0; tick();
        ext_pin_n[0] = 1'b0; tick();
        chk("R8 level req", irq_req, 1);
        chk("R8 no flag", ext_flag, 2'b00);
        ext_pin_n[0] = 1'b1; tick();
        chk("R8 not latched", irq_req, 0);
    endtask

    task automatic t_keep();
        ser_req = 1'b1; tick();
        do_ack(); tick();
        chk("R11 blocked while in service", irq_req, 0);
        do_reti(); tick();
        chk("R11 serial request returns", irq_req, 1);
        chk("R11 serial vec", irq_vec, 32'h0023);
        ser_req = 1'b0; tick(2);
    endtask

    task automatic t_ack_idle();
        do_ack(); tick();
        chk("R12 idle ack no effect", in_svc, 2'b00);
        chk("R12 idle ack no req", irq_req, 0);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        t_reset();
        tick();
        t_vectors();
        t_enable();
        t_order();
        t_prio_nest();
        t_edge();
        t_keep();
        t_ack_idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule